// File: doc/BRIEF.md
# Half-Flash Converter Conversion Sequencer

This block sits on the host side of an external half-flash analog-to-digital converter. It drives the converter's parallel handshake lines and collects each conversion result. The handshake lines are an active-low chip select, an active-low sample/hold strobe and an active-low read strobe. The converter answers on an active-low completion line. A single start pulse runs one full conversion. The 10-bit result then comes out on the result port together with a one-cycle valid pulse.

Two handshake styles are supported, and the style is chosen when a conversion is accepted. In the split style, the sample/hold strobe is held low for a programmed sampling window and then released, and the block waits for the completion line. The read strobe goes low only after completion. In the joined style, the sample/hold and read strobes fall together and rise together, and the converter times its own phases. In both styles the bus is sampled only after a settle delay that follows the synchronised completion edge. This matters because the bus still carries the previous result before that point. If completion never comes, the block releases every strobe and raises a one-cycle error pulse. Before it accepts another start, it waits until the completion line has returned high.

Top module: `adc_hs_ctrl`

## Requirements
- R1: After synchronous reset, `cs_n_o`, `sh_n_o` and `rd_n_o` are high and `res_valid_o` and `timeout_o` are low.
- R2: `start_i` is acted on only when the block is idle. A start pulse during a conversion produces no second sample/hold falling edge and no second result.
- R3: `sh_n_o` and `rd_n_o` are low only in cycles where `cs_n_o` is also low.
- R4: In split style (`tied_mode_i` = 0 at start), `sh_n_o` stays low for exactly SAMPLE_CYC clock cycles, and `rd_n_o` stays high during that time.
- R5: In split style, `rd_n_o` falls only after the synchronised completion line is seen low. It rises again in the cycle the result is captured.
- R6: In joined style (`tied_mode_i` = 1 at start), `sh_n_o` and `rd_n_o` always carry the same level while `cs_n_o` is low.
- R7: The captured result is the value the converter places on the bus after its completion edge for this conversion, never the value it held beforehand.
- R8: Each successful conversion gives exactly one `res_valid_o` pulse, one cycle long, with `res_data_o` holding the result in that cycle.
- R9: If completion does not go low within TIMEOUT_CYC cycles after sampling ends, `timeout_o` pulses for one cycle, all three strobes are high in that cycle, and no valid pulse follows.
- R10: After a result, a start is ignored until the synchronised completion line has returned high.
- R11: The style is latched when a start is accepted. Changing `tied_mode_i` during a conversion does not change that conversion's strobe pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion (used only when idle) |
| tied_mode_i | input | 1 | 1 = joined strobes, 0 = split strobes; sampled at start |
| irq_n_i | input | 1 | Converter completion line, active low, asynchronous |
| adc_data_i | input | 10 | Converter parallel data bus |
| cs_n_o | output | 1 | Chip select to converter, active low |
| sh_n_o | output | 1 | Sample/hold strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| res_valid_o | output | 1 | One-cycle pulse marking a new result |
| res_data_o | output | 10 | Captured conversion result |
| timeout_o | output | 1 | One-cycle pulse when completion never arrives |

## Verification
Each kind of wrong internal state shows up at the ports. A stuck or wrongly loaded sampling counter shows as a sample/hold low width different from SAMPLE_CYC, and this is visible at the first rising edge of that strobe. A wrongly latched style shows as split strobes in joined mode or as an early read, within the sampling window of the same conversion. A settle count that is too short, or a capture taken before completion, returns the stale bus value. This appears at the very next valid pulse. A sequencer that leaves its release state too early accepts a start that was sent right after a result, and chip select falls again within a few cycles.

// File: rtl/adc_hs_pkg.sv
package adc_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_WAIT,
    ST_SETTLE,
    ST_RELEASE
  } hs_state_t;
endpackage

// File: rtl/adc_hs_sync.sv
module adc_hs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sr[0] <= RST_VAL;
        else     sr[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sr[i] <= RST_VAL;
        else     sr[i] <= sr[i-1];
      end
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/adc_hs_timer.sv
module adc_hs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/adc_hs_ctrl.sv
module adc_hs_ctrl
  import adc_hs_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SAMPLE_CYC  = 50,
  parameter int SETTLE_CYC  = 4,
  parameter int TIMEOUT_CYC = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tied_mode_i,
  input  logic              irq_n_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              cs_n_o,
  output logic              sh_n_o,
  output logic              rd_n_o,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              timeout_o
);
  localparam int MAX_AB = (SAMPLE_CYC > SETTLE_CYC) ? SAMPLE_CYC : SETTLE_CYC;
  localparam int MAX_C  = (MAX_AB > TIMEOUT_CYC) ? MAX_AB : TIMEOUT_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  hs_state_t  state, nxt;
  logic       irq_s;
  logic       tmr_ld, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic       tied_q, tied_d;
  logic       cs_d, sh_d, rd_d, valid_d, err_d, cap;

  adc_hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(irq_n_i), .q(irq_s)
  );

  adc_hs_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_ld), .load_val(tmr_val), .zero(tmr_zero)
  );

  always_comb begin
    nxt     = state;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    tied_d  = tied_q;
    cs_d    = cs_n_o;
    sh_d    = sh_n_o;
    rd_d    = rd_n_o;
    valid_d = 1'b0;
    err_d   = 1'b0;
    cap     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_i) begin
          nxt     = ST_SAMPLE;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(SAMPLE_CYC - 1);
          tied_d  = tied_mode_i;
          cs_d    = 1'b0;
          sh_d    = 1'b0;
          rd_d    = ~tied_mode_i;
        end
      end
      ST_SAMPLE: begin
        if (tmr_zero) begin
          nxt     = ST_WAIT;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(TIMEOUT_CYC - 1);
          if (!tied_q) sh_d = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!irq_s) begin
          nxt     = ST_SETTLE;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(SETTLE_CYC - 1);
          rd_d    = 1'b0;
        end else if (tmr_zero) begin
          nxt   = ST_IDLE;
          err_d = 1'b1;
          cs_d  = 1'b1;
          sh_d  = 1'b1;
          rd_d  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_zero) begin
          nxt     = ST_RELEASE;
          cap     = 1'b1;
          valid_d = 1'b1;
          cs_d    = 1'b1;
          sh_d    = 1'b1;
          rd_d    = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (irq_s) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tied_q      <= 1'b0;
      cs_n_o      <= 1'b1;
      sh_n_o      <= 1'b1;
      rd_n_o      <= 1'b1;
      res_valid_o <= 1'b0;
      timeout_o   <= 1'b0;
      res_data_o  <= '0;
    end else begin
      state       <= nxt;
      tied_q      <= tied_d;
      cs_n_o      <= cs_d;
      sh_n_o      <= sh_d;
      rd_n_o      <= rd_d;
      res_valid_o <= valid_d;
      timeout_o   <= err_d;
      if (cap) res_data_o <= adc_data_i;
    end
  end
endmodule

// File: rtl/adc_hs_ctrl_chk.sv
module adc_hs_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sh_n,
  input logic rd_n,
  input logic valid,
  input logic err,
  input logic tied
);
  assert_strobe_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (!sh_n || !rd_n) |-> !cs_n);

  assert_split_no_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!tied && !sh_n) |-> rd_n);

  assert_joined_pair_R6: assert property (@(posedge clk) disable iff (rst)
    (tied && !cs_n) |-> (sh_n == rd_n));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  assert_timeout_release_R9: assert property (@(posedge clk) disable iff (rst)
    err |-> (cs_n && sh_n && rd_n && !valid));

  assert_mode_locked_R11: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n)) |-> $stable(tied));
endmodule

bind adc_hs_ctrl adc_hs_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n_o), .sh_n(sh_n_o), .rd_n(rd_n_o),
  .valid(res_valid_o), .err(timeout_o), .tied(tied_q)
);

// File: tb/adc_hs_ctrl_bench.sv
`timescale 1ns/1ps
module adc_hs_ctrl_bench;
  localparam int DW = 10, S_CYC = 50, ST_CYC = 4, T_CYC = 400;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, tied_mode = 1'b0;
  logic irq_n, cs_n, sh_n, rd_n, res_valid, timeout;
  logic [DW-1:0] bus, res_data;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_hs_ctrl #(.DATA_W(DW), .SAMPLE_CYC(S_CYC), .SETTLE_CYC(ST_CYC),
                .TIMEOUT_CYC(T_CYC)) u_adc_hs_ctrl (
    .clk(clk), .rst(rst), .start_i(start), .tied_mode_i(tied_mode),
    .irq_n_i(irq_n), .adc_data_i(bus), .cs_n_o(cs_n), .sh_n_o(sh_n),
    .rd_n_o(rd_n), .res_valid_o(res_valid), .res_data_o(res_data),
    .timeout_o(timeout)
  );

  // converter model
  bit model_dead = 0;
  int conv_dly = 120;
  logic [DW-1:0] next_val = '0, latched;
  logic p_sh, p_rd;
  bit mbusy;
  int cd, dv;

  always @(posedge clk) begin
    if (rst) begin
      irq_n <= 1'b1; bus <= '0; latched <= '0; mbusy <= 0; cd <= 0; dv <= 0;
      p_sh <= 1'b1; p_rd <= 1'b1;
    end else begin
      if (!mbusy && !cs_n && irq_n) begin
        if (!p_sh && sh_n && rd_n) begin mbusy <= 1; cd <= conv_dly; end
        else if (p_sh && !sh_n && !rd_n) begin mbusy <= 1; cd <= conv_dly; end
      end
      if (mbusy) begin
        if (cs_n) mbusy <= 0;
        else if (!model_dead) begin
          if (cd == 0) begin
            irq_n <= 1'b0; mbusy <= 0; dv <= 4; latched <= next_val;
          end else cd <= cd - 1;
        end
      end
      if (dv > 0) begin
        dv <= dv - 1;
        if (dv == 1) bus <= latched;
      end
      if (!p_rd && rd_n && !cs_n) irq_n <= 1'b1;
      else if (!p_rd && rd_n) irq_n <= 1'b1;
      p_sh <= sh_n; p_rd <= rd_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_sample_width(input bit joined);
    return joined ? -1 : S_CYC;
  endfunction

  task automatic run_conv(input bit joined, input bit dead, input bit flip,
                          input bit extra_start, input bit r10_probe);
    int sh_low = 0, falls = 0, vcnt = 0, bad_gate = 0, bad_joined = 0;
    int bad_split = 0, r10_bad = 0, err_at = -1, v_at = -1, post = 0;
    logic [DW-1:0] got = '0, stale;
    logic prev_sh = 1'b1;
    bit rd_seen_low = 0, early_rd = 0;
    stale = bus;
    model_dead = dead;
    conv_dly = 20 + int'($urandom % 280);
    next_val = DW'($urandom);
    if (next_val == stale) next_val = next_val ^ DW'(1);
    @(negedge clk); start = 1'b1; tied_mode = joined;
    @(negedge clk); start = 1'b0; if (flip) tied_mode = ~joined;
    for (int n = 0; n < 3000; n++) begin
      if (!sh_n && prev_sh) falls++;
      prev_sh = sh_n;
      if (!sh_n && !joined) sh_low++;
      if ((!sh_n || !rd_n) && cs_n) bad_gate++;
      if (joined && !cs_n && (sh_n != rd_n)) bad_joined++;
      if (!joined && !sh_n && !rd_n) bad_split++;
      if (!joined && !rd_n) begin
        rd_seen_low = 1;
        if (irq_n) early_rd = 1;
      end
      if (v_at >= 0 && r10_probe && !cs_n) r10_bad++;
      start = 1'b0;
      if (extra_start && n == 10) start = 1'b1;
      if (res_valid) begin
        vcnt++;
        if (v_at < 0) begin
          v_at = n; got = res_data;
          if (r10_probe) start = 1'b1;
        end
      end
      if (timeout && err_at < 0) begin
        err_at = n;
        chk(cs_n && sh_n && rd_n, "R9 strobes released", {cs_n, sh_n, rd_n}, 7);
      end
      if (v_at >= 0 || err_at >= 0) post++;
      if (post > 10) break;
      @(negedge clk);
    end
    start = 1'b0;
    chk(falls == 1, "R2 single sample edge", falls, 1);
    chk(bad_gate == 0, "R3 strobe outside select", bad_gate, 0);
    if (dead) begin
      chk(err_at >= S_CYC + T_CYC - 2 && err_at <= S_CYC + T_CYC + 2,
          "R9 timeout cycle", err_at, S_CYC + T_CYC);
      chk(vcnt == 0, "R9 no result after timeout", vcnt, 0);
    end else begin
      chk(vcnt == 1, "R8 one valid pulse", vcnt, 1);
      chk(got == next_val, "R7 fresh data", int'(got), int'(next_val));
      if (joined) chk(bad_joined == 0, "R6 joined strobes", bad_joined, 0);
      else begin
        chk(sh_low == exp_sample_width(joined), "R4 sample width", sh_low, S_CYC);
        chk(bad_split == 0 && !early_rd && rd_seen_low, "R5 read after completion",
            int'(early_rd), 0);
      end
      if (flip) chk(joined ? bad_joined == 0 : bad_split == 0,
                    "R11 mode latched at start", joined ? bad_joined : bad_split, 0);
      if (r10_probe) chk(r10_bad == 0, "R10 start held off", r10_bad, 0);
    end
    model_dead = 0;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2417));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n && sh_n && rd_n, "R1 strobes high", {cs_n, sh_n, rd_n}, 7);
    chk(!res_valid && !timeout, "R1 flags low", {res_valid, timeout}, 0);
    run_conv(0, 0, 0, 0, 0);
    run_conv(1, 0, 0, 0, 0);
    run_conv(0, 0, 0, 1, 0);   // R2 start while busy
    run_conv(1, 0, 0, 1, 0);
    run_conv(0, 0, 1, 0, 0);   // R11 flip during conversion
    run_conv(1, 0, 1, 0, 0);
    run_conv(0, 1, 0, 0, 0);   // R9 timeout split
    run_conv(1, 1, 0, 0, 0);   // R9 timeout joined
    run_conv(0, 0, 0, 0, 1);   // R10
    run_conv(1, 0, 0, 0, 1);
    for (int k = 0; k < 16; k++)
      run_conv(bit'($urandom % 2), 0, bit'($urandom % 2), bit'($urandom % 2), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule